// File: doc/BRIEF.md
# Return Address Prediction Stack

This block keeps a small last-in, first-out store of predicted return addresses for the instruction fetch path. Whenever the fetch logic recognises a subroutine call it strobes a push together with the address of the instruction that follows the call. Whenever it recognises a return it strobes a pop and, in that same cycle, takes the current top entry as the predicted target of the return.

The storage is a fixed ring of entries addressed by a single top-of-stack index that moves modulo the depth. The stack never stalls and never reports an error. A push into a full ring silently overwrites the oldest entry. A pop from an empty ring still moves the index and exposes whatever stale address sits there. An occupancy count, saturating at zero and at the depth, drives a valid flag so that the fetch unit knows whether the presented target came from a real push. All updates happen at prediction time, so wrong-path pushes and pops do change the stack. A flush input returns the index and the occupancy to zero so the stack can be recovered after a redirect.

Top module: `ret_addr_stack`

## Requirements
- R1: During and right after reset, valid_o is 0 and tgt_o is 0, because the ring is cleared on reset.
- R2: A push alone stores push_addr_i with its two lowest bits forced to 0. From the next cycle that value is on tgt_o and valid_o is 1.
- R3: tgt_o always shows the current top entry, so it gives the prediction in the cycle of a pop. A pop alone moves the top down one entry, so addresses come back in reverse order of their pushes.
- R4: The ring holds 12 entries and the occupancy never exceeds 12. A 13th push without pops overwrites the oldest entry, so after 12 pops the output has wrapped back to the newest entries.
- R5: A pop alone while occupancy is 0 keeps valid_o at 0 and still moves the top index down modulo 12, wrapping from entry 0 to entry 11. tgt_o then shows the stale contents of that entry.
- R6: A push and a pop in the same cycle replace the top entry with the new masked address. The index and the occupancy stay unchanged.
- R7: A flush sets the index and the occupancy to 0 and overrides any push or pop in the same cycle. The ring contents are kept, so tgt_o shows entry 0 and valid_o is 0.
- R8: In a cycle with no push, pop or flush, tgt_o and valid_o hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| flush_i | input | 1 | Recovery: clears the index and the occupancy |
| push_i | input | 1 | Call detected, store push_addr_i |
| push_addr_i | input | 64 | Return point of the call |
| pop_i | input | 1 | Return detected, drop the top entry |
| tgt_o | output | 64 | Predicted return target (current top entry) |
| valid_o | output | 1 | High when at least one pushed entry is held |

## Verification
The bench builds the block with its default parameters: a depth of 12, which is not a power of two, and 64-bit addresses. This exercises the compare-and-wrap index path rather than natural binary rollover. With 12 entries, the directed sequences can fill the ring past capacity, drain it, and pop from empty across the 0-to-11 wrap within a few dozen cycles. Random sequences then mix same-cycle push and pop and flushes at every occupancy level.

// File: rtl/ras_pkg.sv
package ras_pkg;

   typedef enum logic [1:0] {
      RAS_IDLE = 2'd0,
      RAS_PUSH = 2'd1,
      RAS_POP  = 2'd2,
      RAS_SWAP = 2'd3
   } ras_op_e;

   function automatic ras_op_e ras_decode(input logic push, input logic pop);
      ras_op_e op;
      unique case ({push, pop})
         2'b10:   op = RAS_PUSH;
         2'b01:   op = RAS_POP;
         2'b11:   op = RAS_SWAP;
         default: op = RAS_IDLE;
      endcase
      return op;
   endfunction

endpackage

// File: rtl/ras_ptr.sv
module ras_ptr
   import ras_pkg::*;
#(
   parameter int DEPTH = 12,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  ras_op_e          op,
   output logic [PTR_W-1:0] ptr_q,
   output logic [PTR_W-1:0] ptr_up
);

   localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
   localparam bit POW2 = ((DEPTH & (DEPTH - 1)) == 0);

   logic [PTR_W-1:0] ptr_dn;
   logic [PTR_W-1:0] ptr_d;

   generate
      if (POW2) begin : g_wrap_bin
         assign ptr_up = ptr_q + 1'b1;
         assign ptr_dn = ptr_q - 1'b1;
      end else begin : g_wrap_cmp
         assign ptr_up = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
         assign ptr_dn = (ptr_q == '0) ? LAST : ptr_q - 1'b1;
      end
   endgenerate

   always_comb begin
      ptr_d = ptr_q;
      if (flush) begin
         ptr_d = '0;
      end else begin
         unique case (op)
            RAS_PUSH: ptr_d = ptr_up;
            RAS_POP:  ptr_d = ptr_dn;
            default:  ptr_d = ptr_q;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) ptr_q <= '0;
      else        ptr_q <= ptr_d;
   end

   // index stays inside the ring (R4, R5)
   assert_ptr_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_q <= LAST);

   // pop at index 0 wraps to the last entry (R5)
   assert_ptr_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!flush && op == RAS_POP && ptr_q == '0) |=> ptr_q == LAST);

endmodule

// File: rtl/ras_occ.sv
module ras_occ
   import ras_pkg::*;
#(
   parameter int DEPTH = 12,
   localparam int OCC_W = $clog2(DEPTH + 1)
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    flush,
   input  ras_op_e op,
   output logic    any_o
);

   localparam logic [OCC_W-1:0] FULL = OCC_W'(DEPTH);

   logic [OCC_W-1:0] occ_q;
   logic [OCC_W-1:0] occ_d;

   always_comb begin
      occ_d = occ_q;
      if (flush) begin
         occ_d = '0;
      end else begin
         unique case (op)
            RAS_PUSH: if (occ_q != FULL) occ_d = occ_q + 1'b1;
            RAS_POP:  if (occ_q != '0)   occ_d = occ_q - 1'b1;
            default:  occ_d = occ_q;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) occ_q <= '0;
      else        occ_q <= occ_d;
   end

   assign any_o = (occ_q != '0);

   assert_occ_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      occ_q <= FULL);

   assert_occ_sat_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!flush && op == RAS_PUSH && occ_q == FULL) |=> occ_q == FULL);

   assert_occ_sat_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!flush && op == RAS_POP && occ_q == '0) |=> occ_q == '0);

   assert_occ_swap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!flush && op == RAS_SWAP) |=> $stable(occ_q));

endmodule

// File: rtl/ras_ring.sv
module ras_ring #(
   parameter int DEPTH          = 12,
   parameter int ADDR_W         = 64,
   parameter bit CLEAR_ON_RESET = 1'b1,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [PTR_W-1:0]  wr_idx,
   input  logic [ADDR_W-1:0] wr_data,
   input  logic [PTR_W-1:0]  rd_idx,
   output logic [ADDR_W-1:0] rd_data
);

   logic [ADDR_W-1:0] mem [DEPTH];

   generate
      if (CLEAR_ON_RESET) begin : g_clr
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            end else if (we) begin
               mem[wr_idx] <= wr_data;
            end
         end
      end else begin : g_noclr
         always_ff @(posedge clk) begin
            if (we) mem[wr_idx] <= wr_data;
         end
      end
   endgenerate

   assign rd_data = mem[rd_idx];

endmodule

// File: rtl/ret_addr_stack.sv
module ret_addr_stack
   import ras_pkg::*;
#(
   parameter int DEPTH          = 12,
   parameter int ADDR_W         = 64,
   parameter int ALIGN_BITS     = 2,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush_i,
   input  logic              push_i,
   input  logic [ADDR_W-1:0] push_addr_i,
   input  logic              pop_i,
   output logic [ADDR_W-1:0] tgt_o,
   output logic              valid_o
);

   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("ret_addr_stack: DEPTH must be at least 2");
      end
      if (ALIGN_BITS < 1 || ALIGN_BITS >= ADDR_W) begin : g_bad_align
         $error("ret_addr_stack: ALIGN_BITS must lie in 1..ADDR_W-1");
      end
   endgenerate

   ras_op_e           op;
   logic [PTR_W-1:0]  top_idx;
   logic [PTR_W-1:0]  up_idx;
   logic [PTR_W-1:0]  wr_idx;
   logic              wr_en;
   logic [ADDR_W-1:0] wr_data;

   assign op      = ras_decode(push_i, pop_i);
   assign wr_en   = !flush_i && (op == RAS_PUSH || op == RAS_SWAP);
   assign wr_idx  = (op == RAS_SWAP) ? top_idx : up_idx;
   assign wr_data = {push_addr_i[ADDR_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};

   ras_ptr #(.DEPTH(DEPTH)) u_ptr (
      .clk    (clk),
      .rst_n  (rst_n),
      .flush  (flush_i),
      .op     (op),
      .ptr_q  (top_idx),
      .ptr_up (up_idx)
   );

   ras_occ #(.DEPTH(DEPTH)) u_occ (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (flush_i),
      .op    (op),
      .any_o (valid_o)
   );

   ras_ring #(
      .DEPTH          (DEPTH),
      .ADDR_W         (ADDR_W),
      .CLEAR_ON_RESET (CLEAR_ON_RESET)
   ) u_ring (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (wr_en),
      .wr_idx  (wr_idx),
      .wr_data (wr_data),
      .rd_idx  (top_idx),
      .rd_data (tgt_o)
   );

   // low bits of any presented target are zero (R2)
   assert_tgt_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
      tgt_o[ALIGN_BITS-1:0] == '0);

   assert_push_visible_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && !pop_i && !flush_i) |=>
         (valid_o && tgt_o[ADDR_W-1:ALIGN_BITS] == $past(push_addr_i[ADDR_W-1:ALIGN_BITS])));

   assert_swap_top_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && pop_i && !flush_i) |=>
         (tgt_o[ADDR_W-1:ALIGN_BITS] == $past(push_addr_i[ADDR_W-1:ALIGN_BITS]) && $stable(valid_o)));

   assert_flush_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |=> !valid_o);

   assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!push_i && !pop_i && !flush_i) |=> ($stable(tgt_o) && $stable(valid_o)));

endmodule

// File: tb/sim_ret_addr_stack.sv
module sim_ret_addr_stack;

   localparam int D = 12;
   localparam int AW = 64;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          flush_i = 1'b0;
   logic          push_i = 1'b0;
   logic          pop_i = 1'b0;
   logic [AW-1:0] push_addr_i = '0;
   logic [AW-1:0] tgt_o;
   logic          valid_o;

   int checks = 0;
   int errors = 0;

   logic [AW-1:0] m_mem [D];
   int            m_ptr;
   int            m_occ;

   always #4 clk = ~clk;

   ret_addr_stack u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .flush_i     (flush_i),
      .push_i      (push_i),
      .push_addr_i (push_addr_i),
      .pop_i       (pop_i),
      .tgt_o       (tgt_o),
      .valid_o     (valid_o)
   );

   function automatic logic [AW-1:0] align(input logic [AW-1:0] a);
      return a & ~64'h3;
   endfunction

   function automatic logic [AW-1:0] exp_tgt();
      return m_mem[m_ptr];
   endfunction

   function automatic logic exp_valid();
      return m_occ != 0;
   endfunction

   task automatic model_step(input logic f, input logic pu, input logic po,
                             input logic [AW-1:0] a);
      if (f) begin
         m_ptr = 0;
         m_occ = 0;
      end else if (pu && po) begin
         m_mem[m_ptr] = align(a);
      end else if (pu) begin
         m_ptr = (m_ptr + 1) % D;
         m_mem[m_ptr] = align(a);
         if (m_occ < D) m_occ++;
      end else if (po) begin
         m_ptr = (m_ptr + D - 1) % D;
         if (m_occ > 0) m_occ--;
      end
   endtask

   task automatic check_out(input string tag);
      checks++;
      if (tgt_o !== exp_tgt()) begin
         errors++;
         $display("FAIL %s tgt_o actual %h expected %h", tag, tgt_o, exp_tgt());
      end
      checks++;
      if (valid_o !== exp_valid()) begin
         errors++;
         $display("FAIL %s valid_o actual %b expected %b", tag, valid_o, exp_valid());
      end
   endtask

   // drive at negedge, model after posedge, check at next negedge
   task automatic step(input logic f, input logic pu, input logic po,
                       input logic [AW-1:0] a, input string tag);
      flush_i = f;
      push_i = pu;
      pop_i = po;
      push_addr_i = a;
      @(posedge clk);
      model_step(f, pu, po, a);
      @(negedge clk);
      flush_i = 1'b0;
      push_i = 1'b0;
      pop_i = 1'b0;
      check_out(tag);
   endtask

   initial begin : watchdog
      #(8 * 150000);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : stim
      int seed;
      logic [AW-1:0] a;
      seed = 32'h5eed_0c0d;
      void'($urandom(seed));
      for (int i = 0; i < D; i++) m_mem[i] = '0;
      m_ptr = 0;
      m_occ = 0;

      repeat (3) @(negedge clk);
      check_out("R1 in reset");
      rst_n = 1'b1;
      @(negedge clk);
      check_out("R1 after reset");

      // R2: push with low bits set
      step(0, 1, 0, 64'hdead_beef_0000_1237, "R2 push masked");
      // R8: idle holds
      step(0, 0, 0, 64'hffff_ffff_ffff_ffff, "R8 idle");
      // R3: LIFO order
      step(0, 1, 0, 64'h0000_0000_0000_2000, "R2 push b");
      step(0, 0, 1, '0, "R3 pop b");
      step(0, 0, 1, '0, "R3 pop a");
      // R5: pop when empty wraps 0 -> 11
      step(0, 0, 1, '0, "R5 pop empty wrap");
      step(0, 0, 1, '0, "R5 pop empty again");
      // R7: flush resets to entry 0
      step(1, 0, 0, '0, "R7 flush");
      // R4: 13 pushes then 12 pops
      for (int i = 0; i < D + 1; i++)
         step(0, 1, 0, 64'h1000 + 64'(i) * 64'h44 + 64'h3, "R4 fill");
      for (int i = 0; i < D; i++)
         step(0, 0, 1, '0, "R4 drain wrap");
      step(0, 0, 1, '0, "R5 pop after drain");
      // R6: push and pop together
      step(0, 1, 0, 64'h7770, "R6 setup");
      step(0, 1, 1, 64'h8881, "R6 swap");
      step(0, 1, 1, 64'h9992, "R6 swap again");
      step(0, 0, 1, '0, "R6 pop after swap");
      step(0, 1, 1, 64'haaa3, "R6 swap on empty");
      // R7: flush wins over push and pop
      step(0, 1, 0, 64'hbbb0, "R7 setup");
      step(1, 1, 0, 64'hccc0, "R7 flush over push");
      step(1, 0, 1, '0, "R7 flush over pop");

      // random mix
      for (int n = 0; n < 3000; n++) begin
         int r;
         logic f, pu, po;
         r = $urandom_range(0, 99);
         f = (r < 3);
         pu = (r >= 3 && r < 55) || (r >= 85);
         po = (r >= 40 && r < 99);
         a = {$urandom(), $urandom()};
         step(f, pu, po, a, "R3/R4/R6 random");
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule